// File: doc/BRIEF.md
# DDR2 Burst Column Address Sequencer

This block turns one burst command into the sequence of column addresses the memory expects, one address per data beat. A small mode register holds the burst length (4 or 8 beats) and the burst ordering (sequential or interleaved). When a start command arrives with a starting column, the block walks the beats in the selected order. It drives each address with a valid flag and marks the final beat with a last flag.

Bursts can follow one another with no gap: a start that arrives on the final beat opens the next burst on the very next cycle. There is no command that stops a burst. An 8-beat burst may be cut short by a new start, but only at defined points. A start that arrives at any other point inside a burst is refused and reported. The mode register cannot be changed while a burst is running.

Top module: `ddr_bseq_top`

## Requirements
- R1: After reset `beat_valid`, `beat_last`, `mode_err` and `seq_err` are 0, and the mode is 4-beat sequential.
- R2: A mode write (`mode_wr`=1) with `mode_field[2:0]`=3'b010 selects 4-beat bursts and 3'b011 selects 8-beat bursts. `mode_field[3]`=0 selects sequential order and 1 selects interleaved order. The new mode applies to bursts started after the write has been registered.
- R3: A mode write with any other `mode_field[2:0]` value pulses `mode_err` for one cycle, starting the cycle after the write. The burst length stays as it was, and the order bit `mode_field[3]` is still taken.
- R4: A mode write made while `beat_valid` is 1 is ignored: it changes neither the mode nor `mode_err`.
- R5: In a 4-beat burst, beat k has low two bits equal to (start[1:0]+k) mod 4 in sequential order, or start[1:0] XOR k in interleaved order. Bit 2 equals start bit 2 on every beat.
- R6: In an 8-beat sequential burst, beat k has low two bits equal to (start[1:0]+k) mod 4. Bit 2 is start bit 2 for k<4 and inverted for k>=4. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R7: In an 8-beat interleaved burst, beat k has low three bits equal to start[2:0] XOR k. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R8: Column bits above bit 2 equal the starting column's bits on every beat of the burst.
- R9: The first beat appears the cycle after `start` is sampled. `beat_valid` stays 1 for exactly the burst length, `beat_last` is 1 only on the final beat, and `beat_addr` is 0 while idle.
- R10: A start sampled on the final beat begins the next burst on the following cycle, with no idle cycle between the bursts.
- R11: A start during a 4-beat burst before its final beat is refused. `seq_err` pulses the next cycle and the running burst continues unchanged.
- R12: During an 8-beat burst, a start sampled on beat index 3 or 5 (after 4 or 6 beats) ends the burst and begins the new one on the next cycle without `seq_err`. A start on any other non-final beat is refused as in R11.
- R13: Once started, a burst is never shortened except by an accepted start under R12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode register write strobe |
| mode_field | input | 4 | Bit 3 selects the order; bits 2:0 encode the burst length |
| start | input | 1 | Burst start command |
| start_col | input | COL_W | Starting column address |
| beat_addr | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A beat is being driven |
| beat_last | output | 1 | The current beat is the final beat of its burst |
| mode_err | output | 1 | One-cycle pulse: rejected burst-length code |
| seq_err | output | 1 | One-cycle pulse: refused interruption |

## Verification
The bench checks every starting column in both orders and both lengths. A design that wrapped 8-beat sequential bursts modulo 8 would produce 5,6,7,0 instead of 5,6,7,4. A design that let bit 2 move in 4-beat bursts would leave the nibble. The bench issues starts on the final beat to check that a design cannot insert an idle cycle between bursts. It issues starts on every non-final beat of 8-beat bursts, so a design that accepted beat 2 or refused beat 5 would cut or extend the stream at the wrong place. It also writes illegal length codes, and makes mode writes during a burst, to catch a design that lost the stored length or let a write leak into the following burst.

// File: rtl/ddr_bseq_pkg.sv
package ddr_bseq_pkg;
    localparam int MAX_BEATS = 8;
    localparam int CNT_W     = $clog2(MAX_BEATS);
    localparam int LOW_W     = CNT_W;

    localparam logic [2:0] LEN_CODE_4 = 3'b010;
    localparam logic [2:0] LEN_CODE_8 = 3'b011;

    typedef struct packed {
        logic ilv;   // 1: interleaved order
        logic bl8;   // 1: eight beats
    } bmode_t;
endpackage

// File: rtl/ddr_bseq_mode.sv
module ddr_bseq_mode
    import ddr_bseq_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [3:0]   field,
    input  logic         busy,
    output bmode_t       mode,
    output logic         err
);
    typedef struct packed {
        bmode_t mode;
        logic   err;
    } mstate_t;

    mstate_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (wr && !busy) begin
            st_d.mode.ilv = field[3];
            unique case (field[2:0])
                LEN_CODE_4: st_d.mode.bl8 = 1'b0;
                LEN_CODE_8: st_d.mode.bl8 = 1'b1;
                default:    st_d.err      = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign err  = st_q.err;

    // R4: writes during a burst leave the stored mode alone
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy) |=> $stable(mode));
    // R4: and raise no error
    p_busy_no_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && busy) |=> !err);
endmodule

// File: rtl/ddr_bseq_ctrl.sv
module ddr_bseq_ctrl
    import ddr_bseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    input  bmode_t           mode_in,
    output logic             active,
    output logic [CNT_W-1:0] cnt,
    output bmode_t           bmode,
    output logic [COL_W-1:0] col,
    output logic             last,
    output logic             err
);
    localparam logic [CNT_W-1:0] LAST4 = CNT_W'(3);
    localparam logic [CNT_W-1:0] LAST8 = CNT_W'(7);
    localparam logic [CNT_W-1:0] CUT_A = CNT_W'(3);
    localparam logic [CNT_W-1:0] CUT_B = CNT_W'(5);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        bmode_t           bmode;
        logic [COL_W-1:0] col;
        logic             err;
    } cstate_t;

    cstate_t st_d, st_q;
    logic    is_last, cut_ok, accept;

    always_comb begin
        is_last = st_q.active && (st_q.cnt == (st_q.bmode.bl8 ? LAST8 : LAST4));
        cut_ok  = st_q.active && st_q.bmode.bl8 &&
                  (st_q.cnt == CUT_A || st_q.cnt == CUT_B);
        accept  = start && (!st_q.active || is_last || cut_ok);

        st_d     = st_q;
        st_d.err = start && !accept;
        if (accept) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
            st_d.bmode  = mode_in;
            st_d.col    = start_col;
        end else if (st_q.active) begin
            if (is_last) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active = st_q.active;
    assign cnt    = st_q.cnt;
    assign bmode  = st_q.bmode;
    assign col    = st_q.col;
    assign last   = is_last;
    assign err    = st_q.err;

    // R13: a burst that is not on its last beat keeps running
    p_no_stop_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && !is_last) |=> st_q.active);
    // R11: a refusal can only follow a cycle with a running burst
    p_err_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(st_q.active));
    // R11: a refused start leaves the burst order untouched
    p_refuse_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && st_q.active && !is_last && !st_q.bmode.bl8) |=> $stable(st_q.col));
endmodule

// File: rtl/ddr_bseq_order.sv
module ddr_bseq_order
    import ddr_bseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  bmode_t           bmode,
    input  logic [COL_W-1:0] col,
    output logic [COL_W-1:0] addr
);
    logic [LOW_W-1:0] low;
    logic             nib;
    logic [1:0]       pos;

    always_comb begin
        nib = col[2] ^ (bmode.bl8 & cnt[2]);
        pos = bmode.ilv ? (col[1:0] ^ cnt[1:0]) : (col[1:0] + cnt[1:0]);
        low = {nib, pos};
    end

    generate
        if (COL_W > LOW_W) begin : g_upper
            assign addr = active ? {col[COL_W-1:LOW_W], low} : '0;
        end else begin : g_low_only
            assign addr = active ? low[COL_W-1:0] : '0;
        end
    endgenerate
endmodule

// File: rtl/ddr_bseq_top.sv
module ddr_bseq_top
    import ddr_bseq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [3:0]       mode_field,
    input  logic             start,
    input  logic [COL_W-1:0] start_col,
    output logic [COL_W-1:0] beat_addr,
    output logic             beat_valid,
    output logic             beat_last,
    output logic             mode_err,
    output logic             seq_err
);
    bmode_t           cur_mode, burst_mode;
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic [COL_W-1:0] col;

    ddr_bseq_mode i_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (mode_wr),
        .field (mode_field),
        .busy  (active),
        .mode  (cur_mode),
        .err   (mode_err)
    );

    ddr_bseq_ctrl #(.COL_W(COL_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_col (start_col),
        .mode_in   (cur_mode),
        .active    (active),
        .cnt       (cnt),
        .bmode     (burst_mode),
        .col       (col),
        .last      (beat_last),
        .err       (seq_err)
    );

    ddr_bseq_order #(.COL_W(COL_W)) i_order (
        .active (active),
        .cnt    (cnt),
        .bmode  (burst_mode),
        .col    (col),
        .addr   (beat_addr)
    );

    assign beat_valid = active;

    // R9: last only marks a driven beat
    p_last_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last |-> beat_valid);
    // R8: upper column bits hold across a burst that is not restarted
    p_upper_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_last && !start) |=> $stable(beat_addr[COL_W-1:LOW_W]));
    // R10: a start on the final beat leaves no gap
    p_seamless_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_last && start) |=> beat_valid);
endmodule

// File: tb/test_ddr_bseq_top.sv
module test_ddr_bseq_top;
    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_wr = 1'b0;
    logic [3:0]       mode_field = '0;
    logic             start = 1'b0;
    logic [COL_W-1:0] start_col = '0;
    logic [COL_W-1:0] beat_addr;
    logic             beat_valid, beat_last, mode_err, seq_err;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    ddr_bseq_top #(.COL_W(COL_W)) i_ddr_bseq_top (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_field(mode_field),
        .start(start), .start_col(start_col), .beat_addr(beat_addr),
        .beat_valid(beat_valid), .beat_last(beat_last),
        .mode_err(mode_err), .seq_err(seq_err)
    );

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int exp_addr(input int c, input int k, input bit bl8, input bit ilv);
        int lo2, b2;
        lo2 = ilv ? ((c & 3) ^ (k & 3)) : ((c + k) & 3);
        b2  = (c >> 2) & 1;
        if (bl8 && k >= 4) b2 = b2 ^ 1;
        return (c & ~7) | (b2 << 2) | lo2;
    endfunction

    task automatic step(input bit st, input int c);
        start = st;
        start_col = COL_W'(c);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic set_mode(input logic [3:0] f);
        mode_wr = 1'b1;
        mode_field = f;
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic chk_beat(input string tag, input int c, input int k, input bit bl8, input bit ilv);
        chk({tag, " valid"}, int'(beat_valid), 1);
        chk({tag, " addr"}, int'(beat_addr), exp_addr(c, k, bl8, ilv));
        chk({tag, " last"}, int'(beat_last), (k == (bl8 ? 7 : 3)) ? 1 : 0);
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " idle valid"}, int'(beat_valid), 0);
        chk({tag, " idle addr"}, int'(beat_addr), 0);
    endtask

    task automatic full_burst(input string tag, input int c, input bit bl8, input bit ilv);
        step(1'b1, c);
        for (int k = 0; k < (bl8 ? 8 : 4); k++) begin
            chk_beat(tag, c, k, bl8, ilv);
            step(1'b0, 0);
        end
        chk_idle(tag);
    endtask

    task automatic t_reset();
        chk("R1 valid", int'(beat_valid), 0);
        chk("R1 last", int'(beat_last), 0);
        chk("R1 mode_err", int'(mode_err), 0);
        chk("R1 seq_err", int'(seq_err), 0);
        full_burst("R1 default BL4 seq", 'h1A6, 1'b0, 1'b0);
    endtask

    task automatic t_bl4();
        set_mode(4'b0010);
        chk("R2 mode_err legal", int'(mode_err), 0);
        for (int s = 0; s < 8; s++) full_burst("R5 BL4 seq", 'h2C8 | s, 1'b0, 1'b0);
        set_mode(4'b1010);
        for (int s = 0; s < 8; s++) full_burst("R5 BL4 ilv", 'h130 | s, 1'b0, 1'b1);
    endtask

    task automatic t_bl8();
        set_mode(4'b0011);
        for (int s = 0; s < 8; s++) full_burst("R6 BL8 seq", 'h3F8 | s, 1'b1, 1'b0);
        set_mode(4'b1011);
        for (int s = 0; s < 8; s++) full_burst("R7 BL8 ilv", 'h048 | s, 1'b1, 1'b1);
        full_burst("R8 upper bits", 'h2A5, 1'b1, 1'b1);
    endtask

    task automatic t_bad_mode();
        set_mode(4'b0011);
        set_mode(4'b0111);
        chk("R3 mode_err pulse", int'(mode_err), 1);
        @(negedge clk);
        chk("R3 mode_err drops", int'(mode_err), 0);
        full_burst("R3 length kept, order taken", 'h105, 1'b1, 1'b0);
        set_mode(4'b1000);
        chk("R3 mode_err code 0", int'(mode_err), 1);
        full_burst("R3 length kept, ilv taken", 'h105, 1'b1, 1'b1);
    endtask

    task automatic t_busy_mode();
        set_mode(4'b0011);
        step(1'b1, 'h0E3);
        for (int k = 0; k < 8; k++) begin
            chk_beat("R4 burst during write", 'h0E3, k, 1'b1, 1'b0);
            if (k == 2) begin
                set_mode(4'b1010);
                chk("R4 no mode_err", int'(mode_err), 0);
            end else if (k == 5) begin
                set_mode(4'b0111);
                chk("R4 no mode_err bad code", int'(mode_err), 0);
            end else step(1'b0, 0);
        end
        chk_idle("R4");
        full_burst("R4 mode unchanged", 'h0E3, 1'b1, 1'b0);
    endtask

    task automatic t_seamless();
        set_mode(4'b0010);
        step(1'b1, 'h011);
        for (int k = 0; k < 4; k++) begin
            chk_beat("R10 first BL4", 'h011, k, 1'b0, 1'b0);
            step(k == 3, 'h3FE);
        end
        for (int k = 0; k < 4; k++) begin
            chk_beat("R10 second BL4", 'h3FE, k, 1'b0, 1'b0);
            chk("R10 no seq_err", int'(seq_err), 0);
            step(1'b0, 0);
        end
        chk_idle("R10");
        set_mode(4'b1011);
        step(1'b1, 'h077);
        for (int k = 0; k < 8; k++) begin
            chk_beat("R10 first BL8", 'h077, k, 1'b1, 1'b1);
            step(k == 7, 'h202);
        end
        for (int k = 0; k < 8; k++) begin
            chk_beat("R10 second BL8", 'h202, k, 1'b1, 1'b1);
            step(1'b0, 0);
        end
        chk_idle("R10 end");
    endtask

    task automatic t_bl4_cut();
        set_mode(4'b0010);
        for (int at = 0; at < 3; at++) begin
            step(1'b1, 'h155);
            for (int k = 0; k < 4; k++) begin
                chk_beat("R11 BL4 continues", 'h155, k, 1'b0, 1'b0);
                chk("R11 seq_err", int'(seq_err), (k == at + 1) ? 1 : 0);
                step(k == at, 'h2AA);
            end
            chk_idle("R11 refused start ignored");
        end
    endtask

    task automatic t_bl8_cut();
        set_mode(4'b0011);
        for (int at = 0; at < 7; at++) begin
            bit legal;
            legal = (at == 3 || at == 5);
            step(1'b1, 'h1C6);
            for (int k = 0; k <= (legal ? at : 7); k++) begin
                chk_beat("R12 BL8 before cut", 'h1C6, k, 1'b1, 1'b0);
                if (k == at + 1) chk("R12 refused seq_err", int'(seq_err), 1);
                step(k == at, 'h039);
            end
            if (legal) begin
                chk("R12 legal no seq_err", int'(seq_err), 0);
                for (int k = 0; k < 8; k++) begin
                    chk_beat("R12 new burst after cut", 'h039, k, 1'b1, 1'b0);
                    step(1'b0, 0);
                end
            end
            chk_idle("R13 R12 end");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bl4();
        t_bl8();
        t_bad_mode();
        t_busy_mode();
        t_seamless();
        t_bl4_cut();
        t_bl8_cut();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule